// File: doc/BRIEF.md
# Masked OR Trigger Gate with Busy Lockout

This block turns a bank of eight discriminated detector logic signals and one auxiliary trigger signal into an acquisition trigger for a readout system. Every input is asynchronous and passes through a two-flop synchroniser and a rising-edge detector. Each detector channel passes only if its enable bit is set. The surviving edges are ORed together to form the presented trigger, and the auxiliary edge is ORed in after that.

A trigger is accepted only while the block is idle. Acceptance sets busy. It also produces three outputs: a one-cycle trigger strobe, an ADC gate of programmable length, and a TDC common stop delayed by a programmable number of clock cycles. Triggers that arrive while busy are dropped. Busy clears when the readout logic pulses its done input. Two counters report presented and accepted triggers.

Top module: `trig_gate`

## Requirements
- R1: After reset, busy, strobe_out, gate_out and stop_out are low and both counters read zero.
- R2: A rising edge on a detector channel whose chan_mask bit (bit i enables det_in[i]) is 0 gives no strobe, leaves busy low and leaves presented_cnt unchanged.
- R3: A rising edge on any enabled detector channel is a presented trigger and, when idle, is accepted. Edges on several enabled channels in the same cycle count as one presented trigger.
- R4: A rising edge on aux_in is accepted when idle and does not change presented_cnt.
- R5: busy rises together with strobe_out. A trigger that arrives while busy is rejected: no strobe, accepted_cnt unchanged, presented_cnt still counts it.
- R6: A one-cycle readout_done while busy clears busy on the next cycle. A trigger edge in the same cycle as readout_done is rejected. A trigger edge in the cycle after readout_done is accepted.
- R7: Every accepted trigger gives exactly one strobe_out cycle.
- R8: gate_out goes high in the same cycle as strobe_out and stays high for gate_len cycles. A gate_len of 0 gives 1 cycle.
- R9: stop_out is a one-cycle pulse that comes stop_dly cycles after strobe_out. A stop_dly of 0 gives 1 cycle.
- R10: gate_len and stop_dly are captured at acceptance. Changing them later has no effect on the event in progress.
- R11: An input held high gives only one trigger, even if busy clears while the input is still high.
- R12: presented_cnt counts presented triggers and accepted_cnt counts accepted triggers, one each per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trigger clock (100 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| det_in | input | NCH | Asynchronous discriminated detector signals |
| aux_in | input | 1 | Asynchronous auxiliary trigger, bypasses the mask |
| chan_mask | input | NCH | Per-channel enable for the combined OR |
| gate_len | input | GW | ADC gate length in cycles (0 behaves as 1) |
| stop_dly | input | DW | TDC stop delay in cycles (0 behaves as 1) |
| readout_done | input | 1 | One-cycle pulse that ends the busy interval |
| busy | output | 1 | Event in progress; new triggers are rejected |
| strobe_out | output | 1 | One-cycle accepted-trigger marker for timestamp capture |
| gate_out | output | 1 | ADC gate |
| stop_out | output | 1 | Delayed TDC common stop pulse |
| presented_cnt | output | CW | Count of masked-OR triggers |
| accepted_cnt | output | CW | Count of accepted triggers |

## Verification
The assertions assume that readout_done lasts one cycle and that the settings stay at or below their field widths. The single-strobe and gate checks also assume that readout_done does not clear busy again before an event's stop pulse has gone out. The stimulus follows these assumptions: it pulses readout_done for one cycle, only after the gate and stop outputs of the current event have finished. Inputs change only on the falling clock edge, so synchroniser latency is exact and the same-cycle release case can be placed on a known cycle.

// File: rtl/trig_gate.sv
module trig_gate #(
  parameter int NCH = 8,
  parameter int GW  = 8,
  parameter int DW  = 8,
  parameter int CW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] det_in,
  input  logic           aux_in,
  input  logic [NCH-1:0] chan_mask,
  input  logic [GW-1:0]  gate_len,
  input  logic [DW-1:0]  stop_dly,
  input  logic           readout_done,
  output logic           busy,
  output logic           strobe_out,
  output logic           gate_out,
  output logic           stop_out,
  output logic [CW-1:0]  presented_cnt,
  output logic [CW-1:0]  accepted_cnt
);

  logic [NCH-1:0] d1, d2, d3;
  logic           a1, a2, a3;
  logic [GW-1:0]  gate_cnt;
  logic [DW-1:0]  dly_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d1 <= '0; d2 <= '0; d3 <= '0;
      a1 <= 1'b0; a2 <= 1'b0; a3 <= 1'b0;
    end else begin
      d1 <= det_in; d2 <= d1; d3 <= d2;
      a1 <= aux_in; a2 <= a1; a3 <= a2;
    end
  end

  wire [NCH-1:0] d_rise    = d2 & ~d3;
  wire           a_rise    = a2 & ~a3;
  wire           presented = |(d_rise & chan_mask);
  wire           accept    = (presented | a_rise) & ~busy;

  wire [GW-1:0] gate_load = (gate_len == '0) ? GW'(1) : gate_len;
  wire [DW-1:0] dly_load  = (stop_dly == '0) ? DW'(1) : stop_dly;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy          <= 1'b0;
      strobe_out    <= 1'b0;
      stop_out      <= 1'b0;
      gate_cnt      <= '0;
      dly_cnt       <= '0;
      presented_cnt <= '0;
      accepted_cnt  <= '0;
    end else begin
      strobe_out <= accept;
      stop_out   <= (dly_cnt == DW'(1));
      if (accept)            busy <= 1'b1;
      else if (readout_done) busy <= 1'b0;
      if (accept)                gate_cnt <= gate_load;
      else if (gate_cnt != '0)   gate_cnt <= gate_cnt - GW'(1);
      if (accept)                dly_cnt <= dly_load;
      else if (dly_cnt != '0)    dly_cnt <= dly_cnt - DW'(1);
      if (presented) presented_cnt <= presented_cnt + CW'(1);
      if (accept)    accepted_cnt  <= accepted_cnt + CW'(1);
    end
  end

  assign gate_out = (gate_cnt != '0);

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_out |=> !strobe_out);

  // R5
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_out |-> busy);

  // R5
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> strobe_out);

  // R6
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && readout_done) |=> !busy);

  // R8
  gate_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_out) |-> strobe_out);

  // R12
  accepted_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted_cnt != $past(accepted_cnt)) |-> strobe_out);

endmodule

// File: tb/trig_gate_test.sv
module trig_gate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  det_in = '0;
  logic        aux_in = 1'b0;
  logic [7:0]  chan_mask = '0;
  logic [7:0]  gate_len = '0;
  logic [7:0]  stop_dly = '0;
  logic        readout_done = 1'b0;
  logic        busy, strobe_out, gate_out, stop_out;
  logic [15:0] presented_cnt, accepted_cnt;

  trig_gate uut (
    .clk(clk), .rst_n(rst_n), .det_in(det_in), .aux_in(aux_in),
    .chan_mask(chan_mask), .gate_len(gate_len), .stop_dly(stop_dly),
    .readout_done(readout_done), .busy(busy), .strobe_out(strobe_out),
    .gate_out(gate_out), .stop_out(stop_out),
    .presented_cnt(presented_cnt), .accepted_cnt(accepted_cnt));

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0;
  int cyc = 0;
  int strobe_hits, gate_hits, stop_hits, strobe_at, gate_at, stop_at;
  logic gate_prev = 1'b0;
  int p0, a0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (strobe_out) begin strobe_hits <= strobe_hits + 1; strobe_at <= cyc; end
    if (gate_out) gate_hits <= gate_hits + 1;
    if (gate_out && !gate_prev) gate_at <= cyc;
    if (stop_out) begin stop_hits <= stop_hits + 1; stop_at <= cyc; end
    gate_prev <= gate_out;
  end

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_rec();
    @(negedge clk);
    strobe_hits = 0; gate_hits = 0; stop_hits = 0;
    strobe_at = -1; gate_at = -2; stop_at = -3;
    p0 = presented_cnt; a0 = accepted_cnt;
  endtask

  task automatic fire(input logic [7:0] bits, input logic aux);
    @(negedge clk);
    det_in = bits; aux_in = aux;
    repeat (3) @(negedge clk);
    det_in = '0; aux_in = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  task automatic release_busy();
    @(negedge clk); readout_done = 1'b1;
    @(negedge clk); readout_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 strobe", strobe_out, 0);
    chk("R1 gate", gate_out, 0);
    chk("R1 stop", stop_out, 0);
    chk("R1 presented", presented_cnt, 0);
    chk("R1 accepted", accepted_cnt, 0);
  endtask

  task automatic t_masked();
    chan_mask = 8'h0F;
    clear_rec();
    fire(8'hF0, 1'b0);
    chk("R2 strobe", strobe_hits, 0);
    chk("R2 busy", busy, 0);
    chk("R2 presented", presented_cnt, p0);
  endtask

  task automatic t_unmasked();
    chan_mask = 8'h0F; gate_len = 8'd5; stop_dly = 8'd7;
    clear_rec();
    fire(8'h04, 1'b0);
    chk("R3 strobe", strobe_hits, 1);
    chk("R7 strobe len", strobe_hits, 1);
    chk("R3 busy", busy, 1);
    chk("R12 presented", presented_cnt, p0 + 1);
    chk("R12 accepted", accepted_cnt, a0 + 1);
    chk("R8 gate len", gate_hits, 5);
    chk("R8 gate start", gate_at, strobe_at);
    chk("R9 stop delay", stop_at - strobe_at, 7);
    chk("R9 stop len", stop_hits, 1);
    release_busy();
    chk("R6 released", busy, 0);
    clear_rec();
    fire(8'h03, 1'b0);
    chk("R3 multi strobe", strobe_hits, 1);
    chk("R3 multi presented", presented_cnt, p0 + 1);
    release_busy();
  endtask

  task automatic t_aux();
    clear_rec();
    fire(8'h00, 1'b1);
    chk("R4 strobe", strobe_hits, 1);
    chk("R4 presented", presented_cnt, p0);
    chk("R4 accepted", accepted_cnt, a0 + 1);
    release_busy();
  endtask

  task automatic t_busy();
    fire(8'h01, 1'b0);
    clear_rec();
    fire(8'h02, 1'b0);
    chk("R5 strobe", strobe_hits, 0);
    chk("R5 accepted", accepted_cnt, a0);
    chk("R5 presented", presented_cnt, p0 + 1);
    chk("R5 busy", busy, 1);
    release_busy();
  endtask

  task automatic t_done_same();
    fire(8'h01, 1'b0);
    clear_rec();
    det_in = 8'h02;
    @(negedge clk);
    @(negedge clk); readout_done = 1'b1;
    @(negedge clk); readout_done = 1'b0;
    det_in = '0;
    repeat (30) @(negedge clk);
    chk("R6 same strobe", strobe_hits, 0);
    chk("R6 same busy", busy, 0);
    chk("R6 same accepted", accepted_cnt, a0);
    chk("R6 same presented", presented_cnt, p0 + 1);
    fire(8'h01, 1'b0);
    clear_rec();
    det_in = 8'h02;
    @(negedge clk); readout_done = 1'b1;
    @(negedge clk); readout_done = 1'b0;
    @(negedge clk); det_in = '0;
    repeat (30) @(negedge clk);
    chk("R6 next strobe", strobe_hits, 1);
    chk("R6 next accepted", accepted_cnt, a0 + 1);
    chk("R6 next busy", busy, 1);
    release_busy();
  endtask

  task automatic t_zero();
    gate_len = 8'd0; stop_dly = 8'd0;
    clear_rec();
    fire(8'h08, 1'b0);
    chk("R8 zero gate", gate_hits, 1);
    chk("R9 zero delay", stop_at - strobe_at, 1);
    release_busy();
  endtask

  task automatic t_hold();
    gate_len = 8'd3; stop_dly = 8'd10;
    clear_rec();
    det_in = 8'h01;
    repeat (4) @(negedge clk);
    gate_len = 8'd9; stop_dly = 8'd2; det_in = '0;
    repeat (30) @(negedge clk);
    chk("R10 gate", gate_hits, 3);
    chk("R10 delay", stop_at - strobe_at, 10);
    release_busy();
  endtask

  task automatic t_level();
    gate_len = 8'd2; stop_dly = 8'd2;
    clear_rec();
    det_in = 8'h01;
    repeat (20) @(negedge clk);
    readout_done = 1'b1;
    @(negedge clk); readout_done = 1'b0;
    repeat (20) @(negedge clk);
    det_in = '0;
    repeat (10) @(negedge clk);
    chk("R11 strobe", strobe_hits, 1);
    chk("R11 presented", presented_cnt, p0 + 1);
    chk("R11 busy", busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_masked();
    t_unmasked();
    t_aux();
    t_busy();
    t_done_same();
    t_zero();
    t_hold();
    t_level();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule